// File: doc/BRIEF.md
# Polled/Interrupting Device Register Controller

This block is the register face of a slow peripheral on a CPU memory bus. Software sees a small word-addressed window: a command word, a status word, a latency setting, and a bank of data words. Writing a read or write request to the command word starts a device operation. A countdown timer stands in for the device, and its length comes from the latency setting.

While the operation runs, the status word reports the controller as working. When the countdown ends, the status word reports it as finished. Software then either polls the status word or waits for the level interrupt. It returns the controller to idle by writing the done bit back. A request that arrives while an operation is working or finished is refused, and a busy error code records the refusal.

A read operation loads the data words from the modelled device contents, mixed with a fixed pattern for each word. A write operation stores the data words into the modelled device. The data words cannot be changed while an operation is working.

Top module: `devctl_mmio`

## Requirements
- R1: After reset the command word, the status word and every data word read 0, the latency word reads 4 and irq is low.
- R2: The status word (offset 1) has busy at bit 0, done at bit 1 and the error code at bits 7:4 (0 none, 1 busy-refused, 2 bad opcode); busy and done are never 1 together, and done only rises from the working state.
- R3: A command-word write (offset 0, opcode in bits 1:0, 1 = READ, 2 = WRITE, interrupt enable in bit 4) made while idle sets busy from the next cycle; busy holds for LAT+1 cycles and is then replaced by done, where LAT is the latency word (offset 2, bits 7:0); an accepted command clears the error code.
- R4: On completion of a READ, data word i (offset 8+i) becomes stored word i XOR (i+1)*0x01010101.
- R5: On completion of a WRITE, the data words are copied into the modelled device store, which reads back through a later READ as in R4; the store resets to 0.
- R6: A command write with a nonzero opcode while working or finished changes neither the state, the enable bit nor the last opcode, and sets the error code to 1.
- R7: A status-word write with bit 1 set while finished returns the controller to idle and clears the error code; a status-word write with bit 1 clear has no effect.
- R8: irq is high exactly while done is set and the interrupt enable (command word bit 4) is on, and it holds until the acknowledge.
- R9: Reads of offsets other than 0, 1, 2 and 8..11 return 0, and writes to them have no effect.
- R10: Writes to the data words are ignored while busy.
- R11: In idle, opcode 0 updates only the enable bit, and opcode 3 sets the error code to 2 and starts nothing; the command word reads back the enable at bit 4 and the last accepted opcode at bits 1:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe for this cycle |
| addr | input | 4 | Word offset in the register window |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level completion interrupt |

## Verification
The countdown reaching zero and a new command write can land on the same clock edge. The bench provokes this by timing a WRITE request so that it arrives on the edge where a READ completes. The request must be refused with error code 1, done must appear without busy, and the data words must show the READ result and not the effect of a WRITE. A data-word write is likewise placed inside the working window, and the bench checks that the word keeps its old value after completion.

// File: rtl/devctl_pkg.sv
package devctl_pkg;
  // state encoding equals {done, busy} as seen in the status word
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WORK = 2'b01,
    ST_FIN  = 2'b10
  } dev_state_e;

  localparam logic [1:0] OP_NONE  = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_BAD   = 2'd3;

  localparam logic [3:0] ERR_NONE  = 4'd0;
  localparam logic [3:0] ERR_BUSY  = 4'd1;
  localparam logic [3:0] ERR_BADOP = 4'd2;

  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_LAT  = 2;
  localparam int OFS_DATA = 8;

  localparam int BIT_IEN  = 4;
  localparam int BIT_ACK  = 1;
endpackage

// File: rtl/devctl_regdec.sv
module devctl_regdec
  import devctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_DATA = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_ctrl,
  output logic              sel_stat,
  output logic              sel_lat,
  output logic [N_DATA-1:0] sel_data,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_lat,
  output logic [N_DATA-1:0] wr_data
);
  assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_lat  = (addr == ADDR_W'(OFS_LAT));
  assign wr_ctrl  = wr_en & sel_ctrl;
  assign wr_stat  = wr_en & sel_stat;
  assign wr_lat   = wr_en & sel_lat;

  for (genvar i = 0; i < N_DATA; i++) begin : g_dsel
    assign sel_data[i] = (addr == ADDR_W'(OFS_DATA + i));
    assign wr_data[i]  = wr_en & sel_data[i];
  end
endmodule

// File: rtl/devctl_fsm.sv
module devctl_fsm
  import devctl_pkg::*;
#(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_ien,
  input  logic             ack_wr,
  input  logic             ack_bit,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             done,
  output logic [3:0]       err,
  output logic [1:0]       op,
  output logic             ien,
  output logic             finish
);
  dev_state_e       st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       err_q, err_d;
  logic [1:0]       op_q, op_d;
  logic             ien_q, ien_d;
  logic             fsm_en;

  assign finish = (st_q == ST_WORK) && (cnt_q == '0);
  assign fsm_en = cmd_wr | ack_wr | (st_q == ST_WORK);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = err_q;
    op_d  = op_q;
    ien_d = ien_q;
    case (st_q)
      ST_IDLE: begin
        if (cmd_wr) begin
          case (cmd_op)
            OP_NONE: ien_d = cmd_ien;
            OP_BAD:  err_d = ERR_BADOP;
            default: begin
              st_d  = ST_WORK;
              cnt_d = lat;
              err_d = ERR_NONE;
              op_d  = cmd_op;
              ien_d = cmd_ien;
            end
          endcase
        end
      end
      ST_WORK: begin
        if (cnt_q == '0) st_d = ST_FIN;
        else             cnt_d = cnt_q - 1'b1;
        if (cmd_wr) begin
          if (cmd_op == OP_NONE) ien_d = cmd_ien;
          else                   err_d = ERR_BUSY;
        end
      end
      default: begin
        if (cmd_wr) begin
          if (cmd_op == OP_NONE) ien_d = cmd_ien;
          else                   err_d = ERR_BUSY;
        end
        if (ack_wr && ack_bit) begin
          st_d  = ST_IDLE;
          err_d = ERR_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_q <= ERR_NONE;
      op_q  <= OP_NONE;
      ien_q <= 1'b0;
    end else if (fsm_en) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      op_q  <= op_d;
      ien_q <= ien_d;
    end
  end

  assign busy = st_q[0];
  assign done = st_q[1];
  assign err  = err_q;
  assign op   = op_q;
  assign ien  = ien_q;
endmodule

// File: rtl/devctl_databuf.sv
module devctl_databuf
  import devctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_DATA = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_DATA-1:0]              wr_data,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           busy,
  input  logic                           finish,
  input  logic [1:0]                     op,
  output logic [N_DATA-1:0][DATA_W-1:0]  data_q
);
  localparam logic [DATA_W-1:0] REP = {(DATA_W/8){8'h01}};

  logic fin_rd, fin_wr;
  assign fin_rd = finish && (op == OP_READ);
  assign fin_wr = finish && (op == OP_WRITE);

  for (genvar i = 0; i < N_DATA; i++) begin : g_word
    localparam logic [DATA_W-1:0] PAT = REP * DATA_W'(i + 1);
    logic [DATA_W-1:0] store_q, store_d, data_d;
    logic              data_en, store_en;

    always_comb begin
      data_en  = fin_rd | (wr_data[i] & ~busy);
      data_d   = fin_rd ? (store_q ^ PAT) : wdata;
      store_en = fin_wr;
      store_d  = data_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i] <= '0;
        store_q   <= '0;
      end else begin
        if (data_en)  data_q[i] <= data_d;
        if (store_en) store_q   <= store_d;
      end
    end
  end
endmodule

// File: rtl/devctl_mmio.sv
module devctl_mmio
  import devctl_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int N_DATA  = 4,
  parameter int LAT_W   = 8,
  parameter int DEF_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [1:0]               rst_sync_q;
  logic                     rst_sync_n;
  logic                     sel_ctrl, sel_stat, sel_lat;
  logic                     wr_ctrl, wr_stat, wr_lat;
  logic [N_DATA-1:0]        sel_data, wr_data;
  logic                     busy_w, done_w, ien_w, finish_w;
  logic [3:0]               err_w;
  logic [1:0]               op_w;
  logic [LAT_W-1:0]         lat_q;
  logic [N_DATA-1:0][DATA_W-1:0] data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  devctl_regdec #(.ADDR_W(ADDR_W), .N_DATA(N_DATA)) u_dec (
    .wr_en(wr_en), .addr(addr),
    .sel_ctrl(sel_ctrl), .sel_stat(sel_stat), .sel_lat(sel_lat), .sel_data(sel_data),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_lat(wr_lat), .wr_data(wr_data)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  lat_q <= LAT_W'(DEF_LAT);
    else if (wr_lat)  lat_q <= wdata[LAT_W-1:0];
  end

  devctl_fsm #(.LAT_W(LAT_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_wr(wr_ctrl), .cmd_op(wdata[1:0]), .cmd_ien(wdata[BIT_IEN]),
    .ack_wr(wr_stat), .ack_bit(wdata[BIT_ACK]), .lat(lat_q),
    .busy(busy_w), .done(done_w), .err(err_w), .op(op_w), .ien(ien_w),
    .finish(finish_w)
  );

  devctl_databuf #(.DATA_W(DATA_W), .N_DATA(N_DATA)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .wr_data(wr_data), .wdata(wdata),
    .busy(busy_w), .finish(finish_w), .op(op_w), .data_q(data_w)
  );

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[BIT_IEN] = ien_w;
      rdata[1:0]     = op_w;
    end
    if (sel_stat) rdata[7:0] = {err_w, 2'b00, done_w, busy_w};
    if (sel_lat)  rdata[LAT_W-1:0] = lat_q;
    for (int i = 0; i < N_DATA; i++) begin
      if (sel_data[i]) rdata = data_w[i];
    end
  end

  assign irq = ien_w & done_w;
endmodule

// File: rtl/devctl_mmio_chk.sv
module devctl_mmio_chk
  import devctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              busy,
  input logic              done,
  input logic [3:0]        err,
  input logic              irq
);
  logic cmd_go, cmd_any;
  assign cmd_any = wr_en && (addr == ADDR_W'(OFS_CTRL)) && (wdata[1:0] != OP_NONE);
  assign cmd_go  = cmd_any && (wdata[1:0] != OP_BAD);

  a_r2_never_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && !done) |=> (busy && err == ERR_NONE));

  a_r6_refuse_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any && (busy || done)) |=> (err == ERR_BUSY));

  a_r7_ack_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wr_en && addr == ADDR_W'(OFS_STAT) && wdata[BIT_ACK]) |=>
      (!busy && !done && err == ERR_NONE));

  a_r8_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);
endmodule

bind devctl_mmio devctl_mmio_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy_w), .done(done_w), .err(err_w), .irq(irq)
);

// File: tb/devctl_mmio_test.sv
module devctl_mmio_test;
  localparam int CLK_P = 10;

  logic        clk, rst_n, wr_en, irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  int          n_run, n_fail;
  bit          ended;

  devctl_mmio uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [3:0]  a;
    logic [31:0] d;   // write data, or expected read data
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 32'h0000_0000},   // R1 command word
    '{1'b0, 4'h1, 32'h0000_0000},   // R1 status word
    '{1'b0, 4'h2, 32'h0000_0004},   // R1 latency word
    '{1'b0, 4'h8, 32'h0000_0000},   // R1 data word 0
    '{1'b1, 4'h8, 32'h1111_1111},
    '{1'b1, 4'h9, 32'h2222_2222},
    '{1'b0, 4'h8, 32'h1111_1111},   // data readback
    '{1'b1, 4'h3, 32'hDEAD_BEEF},   // R9 write to hole
    '{1'b0, 4'h3, 32'h0000_0000},   // R9
    '{1'b0, 4'hF, 32'h0000_0000},   // R9
    '{1'b1, 4'h2, 32'h0000_0002},   // latency = 2
    '{1'b0, 4'h2, 32'h0000_0002},
    '{1'b1, 4'h0, 32'h0000_0010},   // R11 opcode 0, enable on
    '{1'b0, 4'h0, 32'h0000_0010},   // R11
    '{1'b0, 4'h1, 32'h0000_0000},   // R11 nothing started
    '{1'b1, 4'h0, 32'h0000_0003},   // R11 bad opcode
    '{1'b0, 4'h1, 32'h0000_0020},   // R11 error 2
    '{1'b0, 4'h0, 32'h0000_0010}    // R11 enable kept
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
  endtask

  task automatic bus_peek(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    #1 v = rdata;
  endtask

  task automatic bus_rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_peek(a, v);
    chk(tag, v, exp);
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog all-R act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    int nb;
    n_run = 0; n_fail = 0; ended = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) bus_wr(VEC[k].a, VEC[k].d);
      else           bus_rd($sformatf("R1/R9/R11 vec %0d", k), VEC[k].a, VEC[k].d);
    end

    // WRITE with interrupt enable, latency 2 -> busy for 3 cycles
    bus_wr(4'h0, 32'h0000_0012);
    bus_rd("R3 busy c1", 4'h1, 32'h0000_0001);
    bus_wr(4'h8, 32'h0000_FFFF);                    // R10 while busy
    bus_rd("R3 busy c3", 4'h1, 32'h0000_0001);
    bus_rd("R3 done c4", 4'h1, 32'h0000_0002);
    chk("R8 irq at done", {31'b0, irq}, 32'h1);
    bus_rd("R10 data kept", 4'h8, 32'h1111_1111);
    bus_wr(4'h0, 32'h0000_0001);                    // R6 refused
    bus_rd("R6 status", 4'h1, 32'h0000_0012);
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    bus_rd("R6 ctrl kept", 4'h0, 32'h0000_0012);
    bus_wr(4'h1, 32'h0000_0001);                    // R7 no ack bit
    bus_rd("R7 no effect", 4'h1, 32'h0000_0012);
    bus_wr(4'h1, 32'h0000_0002);
    bus_rd("R7 acked", 4'h1, 32'h0000_0000);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // READ without interrupt, count busy cycles
    bus_wr(4'h0, 32'h0000_0001);
    nb = 0;
    for (int k = 0; k < 20; k++) begin
      bus_peek(4'h1, v);
      if (v == 32'h1) nb++;
      else break;
    end
    chk("R3 busy length", nb, 32'd3);
    chk("R2 final status", v, 32'h0000_0002);
    chk("R8 irq disabled", {31'b0, irq}, 32'h0);
    bus_rd("R5 d0", 4'h8, 32'h1010_1010);
    bus_rd("R5 d1", 4'h9, 32'h2020_2020);
    bus_rd("R4 d2", 4'hA, 32'h0303_0303);
    bus_rd("R4 d3", 4'hB, 32'h0404_0404);
    bus_wr(4'h1, 32'h0000_0002);

    // collision: WRITE request lands on READ completion edge
    bus_wr(4'h2, 32'h0000_0003);
    bus_wr(4'h0, 32'h0000_0001);
    bus_rd("R3 busy lat3", 4'h1, 32'h0000_0001);
    idle();
    idle();
    bus_wr(4'h0, 32'h0000_0002);
    bus_rd("R6 collision status", 4'h1, 32'h0000_0012);
    bus_rd("R6 collision ctrl", 4'h0, 32'h0000_0001);
    bus_rd("R4 collision data", 4'h8, 32'h0101_0101 ^ 32'h1111_1111);
    bus_wr(4'h1, 32'h0000_0002);
    bus_rd("R7 idle", 4'h1, 32'h0000_0000);

    // reset during an operation
    bus_wr(4'h0, 32'h0000_0011);
    idle();
    rst_n = 1'b0;
    #(CLK_P);
    rst_n = 1'b1;
    repeat (3) idle();
    bus_rd("R1 status after reset", 4'h1, 32'h0000_0000);
    bus_rd("R1 ctrl after reset", 4'h0, 32'h0000_0000);
    bus_rd("R1 lat after reset", 4'h2, 32'h0000_0004);
    bus_rd("R1 data after reset", 4'h8, 32'h0000_0000);
    chk("R1 irq after reset 2", {31'b0, irq}, 32'h0);

    // store reset: READ returns pure pattern
    bus_wr(4'h0, 32'h0000_0001);
    repeat (8) idle();
    bus_rd("R5 store reset", 4'h9, 32'h0202_0202);

    summary();
  end
endmodule